// File: doc/BRIEF.md
# Bufferless Deflection Mesh Router

This router sits at one node of a two-dimensional mesh. It keeps no input queues. Each cycle it takes whatever flits arrive on its four neighbour links, plus at most one flit from the local core. It sorts them by age and gives every one of them an output. Each flit goes to an output that brings it nearer its destination when one is still free. Otherwise it is deflected onto some other free link. A flit addressed to this node leaves on the ejection output.

Routing and arbitration are decided in the cycle the flits arrive. The decision and the flits are then captured in a pipeline register. The switch traversal happens from that register, so a flit that is present at clock edge k is driven on its output from edge k until edge k+1.

Only the injection port carries back-pressure, through a valid/ready pair. A flit is taken from the local core on an edge where `inj_valid` and `inj_ready` are both high. `inj_ready` depends only on which link inputs are occupied in that cycle, never on `inj_valid`. The link outputs and the ejection output have no ready signal: a bufferless router cannot hold a flit back, so the receivers must always accept. Each flit is a header plus a payload, packed from the least significant bit upward:
- payload, `PAY_W` bits;
- destination x, then destination y, each log2 of the mesh dimension wide;
- age, `AGE_W` bits, where a larger value means an older flit.

The router passes each flit through unchanged.

Top module: `defl_router`

## Requirements
- R1: Every flit accepted at an edge appears on exactly one output (link or ejection) in the following cycle, so the number of valid outputs equals the number of flits accepted at the previous edge. A link or ejection output that carries no flit is invalid.
- R2: `inj_ready` is high exactly when fewer link inputs are valid than the node has links. With every existing link input valid, an offered injection flit is not taken and appears on no output.
- R3: A flit present on an input at edge k is driven on its output from edge k to edge k+1 with all bits unchanged. It is gone one cycle later if nothing new arrives.
- R4: Productive directions come from the header and the node coordinates:
  - north when dest y > node y;
  - south when dest y < node y;
  - east when dest x > node x;
  - west when dest x < node x.

  Port indices are north 0, east 1, south 2, west 3.
- R5: Outputs are granted one flit at a time, in falling age order. Among equal ages the lower slot index goes first, with the links at slots 0 to 3 and injection at slot 4.
- R6: When no productive output is free, the flit is deflected to the lowest-index free link that exists at this node.
- R7: When several productive outputs are free, the flit takes the lowest-index one.
- R8: A flit whose destination equals the node coordinates takes the ejection output if it is still free. A later-ranked local flit is deflected as in R6.
- R9: Links that fall off the mesh edge do not exist:
  - north when node y = MESH_Y-1;
  - south when node y = 0;
  - east when node x = MESH_X-1;
  - west when node x = 0.

  A missing link is never driven valid, and a flit offered on its input is ignored.
- R10: While reset is asserted, and in the first cycle after it, all outputs are invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| my_x | input | X_W | Node x coordinate |
| my_y | input | Y_W | Node y coordinate |
| in_valid | input | 4 | Link input valid, bit = port index |
| in_data | input | 4*FW | Link input flits, port p at bits p*FW |
| inj_valid | input | 1 | Local injection flit offered |
| inj_data | input | FW | Local injection flit |
| inj_ready | output | 1 | Injection accepted this cycle if valid |
| out_valid | output | 4 | Link output valid, bit = port index |
| out_data | output | 4*FW | Link output flits |
| ej_valid | output | 1 | Ejection flit valid |
| ej_data | output | FW | Ejection flit |

## Verification
The only state in the block is the one-cycle stage register. A wrong grant or a corrupt captured flit therefore shows at the ports in the very next cycle, and it shows in one of these ways:
- a flit that is missing or duplicated, which changes the output count;
- a flit on the wrong port;
- a flit driven on a link that does not exist.

The directed cases tag every payload and locate each tag among the outputs, so a misrouting is caught in the cycle it occurs.

// File: rtl/defl_pkg.sv
package defl_pkg;
  localparam int NLINK = 4;
  localparam int NSLOT = 5;
  localparam int NOUT  = 5;
  localparam int SEL_W = 3;
  typedef enum logic [SEL_W-1:0] {
    PORT_N = 3'd0, PORT_E = 3'd1, PORT_S = 3'd2, PORT_W = 3'd3, PORT_LOC = 3'd4
  } port_e;
endpackage

// File: rtl/defl_route.sv
module defl_route #(
  parameter int X_W = 2,
  parameter int Y_W = 2
) (
  input  logic [X_W-1:0] dst_x,
  input  logic [Y_W-1:0] dst_y,
  input  logic [X_W-1:0] my_x,
  input  logic [Y_W-1:0] my_y,
  output logic [3:0]     prod,
  output logic           is_local
);
  import defl_pkg::*;
  always_comb begin
    prod         = '0;
    prod[PORT_N] = dst_y > my_y;
    prod[PORT_S] = dst_y < my_y;
    prod[PORT_E] = dst_x > my_x;
    prod[PORT_W] = dst_x < my_x;
    is_local     = (dst_x == my_x) && (dst_y == my_y);
  end
endmodule

// File: rtl/defl_alloc.sv
module defl_alloc #(
  parameter int AGE_W = 8
) (
  input  logic [defl_pkg::NSLOT-1:0]                 vld,
  input  logic [defl_pkg::NSLOT-1:0][AGE_W-1:0]      age,
  input  logic [defl_pkg::NSLOT-1:0][3:0]            prod,
  input  logic [defl_pkg::NSLOT-1:0]                 loc,
  input  logic [3:0]                                 links,
  output logic [defl_pkg::NOUT-1:0]                  o_vld,
  output logic [defl_pkg::NOUT-1:0][defl_pkg::SEL_W-1:0] o_src
);
  import defl_pkg::*;
  logic [SEL_W-1:0] rank [NSLOT];
  logic [NOUT-1:0]  free;
  logic             got;

  always_comb begin
    for (int i = 0; i < NSLOT; i++) begin
      rank[i] = '0;
      for (int j = 0; j < NSLOT; j++)
        if (j != i && vld[j] &&
            ((age[j] > age[i]) || (age[j] == age[i] && j < i)))
          rank[i] = rank[i] + 3'd1;
    end
    free  = {1'b1, links};
    o_vld = '0;
    o_src = '0;
    got   = 1'b0;
    for (int r = 0; r < NSLOT; r++) begin
      for (int i = 0; i < NSLOT; i++) begin
        if (vld[i] && rank[i] == SEL_W'(r)) begin
          got = 1'b0;
          if (loc[i] && free[PORT_LOC]) begin
            got = 1'b1; free[PORT_LOC] = 1'b0;
            o_vld[PORT_LOC] = 1'b1; o_src[PORT_LOC] = SEL_W'(i);
          end
          for (int p = 0; p < NLINK; p++)
            if (!got && prod[i][p] && free[p]) begin
              got = 1'b1; free[p] = 1'b0; o_vld[p] = 1'b1; o_src[p] = SEL_W'(i);
            end
          for (int p = 0; p < NLINK; p++)
            if (!got && free[p]) begin
              got = 1'b1; free[p] = 1'b0; o_vld[p] = 1'b1; o_src[p] = SEL_W'(i);
            end
        end
      end
    end
  end
endmodule

// File: rtl/defl_xbar.sv
module defl_xbar #(
  parameter int FW = 16
) (
  input  logic [defl_pkg::NSLOT-1:0][FW-1:0]              flit_q,
  input  logic [defl_pkg::NOUT-1:0]                       vld_q,
  input  logic [defl_pkg::NOUT-1:0][defl_pkg::SEL_W-1:0]  src_q,
  output logic [defl_pkg::NOUT-1:0]                       x_vld,
  output logic [defl_pkg::NOUT-1:0][FW-1:0]               x_data
);
  import defl_pkg::*;
  for (genvar o = 0; o < NOUT; o++) begin : g_out
    always_comb begin
      x_vld[o]  = vld_q[o];
      x_data[o] = '0;
      for (int s = 0; s < NSLOT; s++)
        if (src_q[o] == SEL_W'(s)) x_data[o] = flit_q[s];
    end
  end
endmodule

// File: rtl/defl_router.sv
module defl_router #(
  parameter int MESH_X = 4,
  parameter int MESH_Y = 4,
  parameter int AGE_W  = 8,
  parameter int PAY_W  = 128,
  localparam int X_W   = (MESH_X > 1) ? $clog2(MESH_X) : 1,
  localparam int Y_W   = (MESH_Y > 1) ? $clog2(MESH_Y) : 1,
  localparam int FW    = PAY_W + X_W + Y_W + AGE_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [X_W-1:0]  my_x,
  input  logic [Y_W-1:0]  my_y,
  input  logic [3:0]      in_valid,
  input  logic [4*FW-1:0] in_data,
  input  logic            inj_valid,
  input  logic [FW-1:0]   inj_data,
  output logic            inj_ready,
  output logic [3:0]      out_valid,
  output logic [4*FW-1:0] out_data,
  output logic            ej_valid,
  output logic [FW-1:0]   ej_data
);
  import defl_pkg::*;

  logic [3:0]                   links;
  logic [NSLOT-1:0][FW-1:0]     slot;
  logic [NSLOT-1:0]             vld;
  logic [NSLOT-1:0][AGE_W-1:0]  age;
  logic [NSLOT-1:0][3:0]        prod;
  logic [NSLOT-1:0]             loc;
  logic [NOUT-1:0]              g_vld;
  logic [NOUT-1:0][SEL_W-1:0]   g_src;
  logic [NSLOT-1:0][FW-1:0]     flit_q;
  logic [NOUT-1:0]              vld_q;
  logic [NOUT-1:0][SEL_W-1:0]   src_q;
  logic [NOUT-1:0]              x_vld;
  logic [NOUT-1:0][FW-1:0]      x_data;
  int                           n_busy, n_link;

  always_comb begin
    links[PORT_N] = my_y != Y_W'(MESH_Y - 1);
    links[PORT_E] = my_x != X_W'(MESH_X - 1);
    links[PORT_S] = my_y != '0;
    links[PORT_W] = my_x != '0;
    n_busy = 0;
    n_link = 0;
    for (int p = 0; p < NLINK; p++) begin
      if (links[p]) n_link = n_link + 1;
      if (links[p] && in_valid[p]) n_busy = n_busy + 1;
    end
  end

  assign inj_ready = n_busy < n_link;

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    if (i < NLINK) begin : g_link
      assign slot[i] = in_data[i*FW +: FW];
      assign vld[i]  = in_valid[i] & links[i];
    end else begin : g_inj
      assign slot[i] = inj_data;
      assign vld[i]  = inj_valid & inj_ready;
    end
    assign age[i] = slot[i][FW-1 -: AGE_W];
    defl_route #(.X_W(X_W), .Y_W(Y_W)) u_route (
      .dst_x   (slot[i][PAY_W +: X_W]),
      .dst_y   (slot[i][PAY_W+X_W +: Y_W]),
      .my_x    (my_x),
      .my_y    (my_y),
      .prod    (prod[i]),
      .is_local(loc[i])
    );
  end

  defl_alloc #(.AGE_W(AGE_W)) u_alloc (
    .vld(vld), .age(age), .prod(prod), .loc(loc), .links(links),
    .o_vld(g_vld), .o_src(g_src)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      src_q <= '0;
    end else begin
      vld_q <= g_vld;
      src_q <= g_src;
    end
  end

  always_ff @(posedge clk) flit_q <= slot;

  defl_xbar #(.FW(FW)) u_xbar (
    .flit_q(flit_q), .vld_q(vld_q), .src_q(src_q),
    .x_vld(x_vld), .x_data(x_data)
  );

  for (genvar p = 0; p < NLINK; p++) begin : g_oport
    assign out_valid[p]          = x_vld[p];
    assign out_data[p*FW +: FW]  = x_data[p];
  end
  assign ej_valid = x_vld[PORT_LOC];
  assign ej_data  = x_data[PORT_LOC];
endmodule

// File: rtl/defl_router_chk.sv
module defl_router_chk #(
  parameter int MESH_X = 4,
  parameter int MESH_Y = 4,
  parameter int AGE_W  = 8,
  parameter int PAY_W  = 128,
  localparam int X_W   = (MESH_X > 1) ? $clog2(MESH_X) : 1,
  localparam int Y_W   = (MESH_Y > 1) ? $clog2(MESH_Y) : 1,
  localparam int FW    = PAY_W + X_W + Y_W + AGE_W
) (
  input logic            clk,
  input logic            rst_n,
  input logic [X_W-1:0]  my_x,
  input logic [Y_W-1:0]  my_y,
  input logic [3:0]      in_valid,
  input logic            inj_valid,
  input logic            inj_ready,
  input logic [3:0]      out_valid,
  input logic            ej_valid,
  input logic [FW-1:0]   ej_data
);
  logic [3:0] lk;
  logic       past_ok;
  assign lk = {my_x != '0, my_y != '0, my_x != X_W'(MESH_X - 1), my_y != Y_W'(MESH_Y - 1)};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;

  AST_FULL_BLOCKS_INJ: assert property (@(posedge clk) disable iff (!rst_n)
    ((in_valid & lk) == lk) |-> !inj_ready); // R2

  AST_NO_EDGE_LINK: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> ((out_valid & ~$past(lk)) == 4'b0)); // R9

  AST_FLIT_CONSERVED: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> ($countones({out_valid, ej_valid}) ==
                 $past($countones({in_valid & lk, inj_valid & inj_ready})))); // R1

  AST_EJECT_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && ej_valid) |->
      (ej_data[PAY_W +: X_W] == $past(my_x) && ej_data[PAY_W+X_W +: Y_W] == $past(my_y))); // R8

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !past_ok |-> (out_valid == 4'b0 && !ej_valid)); // R10
endmodule

bind defl_router defl_router_chk #(
  .MESH_X(MESH_X), .MESH_Y(MESH_Y), .AGE_W(AGE_W), .PAY_W(PAY_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .my_x(my_x), .my_y(my_y), .in_valid(in_valid),
  .inj_valid(inj_valid), .inj_ready(inj_ready), .out_valid(out_valid),
  .ej_valid(ej_valid), .ej_data(ej_data)
);

// File: tb/tb_defl_router.sv
`timescale 1ns/1ps
module tb_defl_router;
  localparam int MX = 4, MY = 4, AW = 8, PW = 128;
  localparam int XW = 2, YW = 2;
  localparam int FW = PW + XW + YW + AW;
  localparam int NONE = 5, DUP = 6;

  logic clk = 0, rst_n = 0;
  logic [XW-1:0] my_x = 1;
  logic [YW-1:0] my_y = 1;
  logic [3:0] in_valid = 0;
  logic [4*FW-1:0] in_data = 0;
  logic inj_valid = 0;
  logic [FW-1:0] inj_data = 0;
  logic inj_ready;
  logic [3:0] out_valid;
  logic [4*FW-1:0] out_data;
  logic ej_valid;
  logic [FW-1:0] ej_data;
  int checks = 0, errors = 0;
  logic rdy_seen;
  logic done = 0;

  always #10 clk = ~clk;

  defl_router #(.MESH_X(MX), .MESH_Y(MY), .AGE_W(AW), .PAY_W(PW)) dut (
    .clk(clk), .rst_n(rst_n), .my_x(my_x), .my_y(my_y),
    .in_valid(in_valid), .in_data(in_data), .inj_valid(inj_valid),
    .inj_data(inj_data), .inj_ready(inj_ready), .out_valid(out_valid),
    .out_data(out_data), .ej_valid(ej_valid), .ej_data(ej_data));

  function automatic logic [FW-1:0] mk(int age, int dx, int dy, int tag);
    return {AW'(age), YW'(dy), XW'(dx), PW'(tag) ^ {8'hA5, {(PW-8){1'b0}}}};
  endfunction

  function automatic int where(int tag);
    int w = NONE;
    logic [15:0] t = 16'(tag);
    for (int p = 0; p < 4; p++)
      if (out_valid[p] && out_data[p*FW +: 16] == t) w = (w == NONE) ? p : DUP;
    if (ej_valid && ej_data[15:0] == t) w = (w == NONE) ? 4 : DUP;
    return w;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // drive one cycle at negedge, sample at the next negedge (after one edge)
  task automatic step(logic [3:0] v, logic [FW-1:0] d0, logic [FW-1:0] d1,
                      logic [FW-1:0] d2, logic [FW-1:0] d3, logic iv, logic [FW-1:0] id);
    @(negedge clk);
    in_valid = v; in_data = {d3, d2, d1, d0}; inj_valid = iv; inj_data = id;
    #1 rdy_seen = inj_ready;
    @(negedge clk);
    in_valid = 0; inj_valid = 0;
  endtask

  function automatic int nout();
    return $countones({out_valid, ej_valid});
  endfunction

  task automatic t_reset();
    chk("R10 outputs idle after reset", nout(), 0);
    @(negedge clk);
    chk("R10 outputs idle one cycle later", nout(), 0);
  endtask

  task automatic t_single();
    logic [FW-1:0] f = mk(4, 3, 1, 11);
    my_x = 1; my_y = 1;
    step(4'b1000, 0, 0, 0, f, 0, 0);
    chk("R4 lone flit goes east", where(11), 1);
    chk("R3 flit bits unchanged", int'(out_data[1*FW +: FW] == f), 1);
    chk("R1 one output", nout(), 1);
    @(negedge clk);
    chk("R3 gone one cycle later", nout(), 0);
  endtask

  task automatic t_two_prod();
    step(4'b0100, 0, 0, mk(2, 2, 2, 12), 0, 0, 0);
    chk("R7 north before east", where(12), 0);
  endtask

  task automatic t_contend();
    step(4'b0101, mk(5, 3, 1, 21), 0, mk(9, 3, 1, 22), 0, 0, 0);
    chk("R5 older wins east", where(22), 1);
    chk("R6 younger deflected north", where(21), 0);
  endtask

  task automatic t_tie();
    step(4'b1100, 0, 0, mk(7, 3, 1, 31), mk(7, 3, 1, 32), 0, 0);
    chk("R5 tie lower index south wins", where(31), 1);
    chk("R6 tie loser to north", where(32), 0);
  endtask

  task automatic t_eject();
    step(4'b1010, 0, mk(3, 1, 1, 41), 0, mk(8, 1, 1, 42), 0, 0);
    chk("R8 oldest local ejects", where(42), 4);
    chk("R8 second local deflected north", where(41), 0);
    chk("R1 two outputs", nout(), 2);
  endtask

  task automatic t_full();
    step(4'b1111, mk(1, 3, 1, 51), mk(2, 3, 1, 52), mk(3, 3, 1, 53), mk(4, 3, 1, 54),
         1, mk(200, 1, 3, 55));
    chk("R2 ready low when all links busy", int'(rdy_seen), 0);
    chk("R2 offered injection not taken", where(55), NONE);
    chk("R5 oldest west-in to east", where(54), 1);
    chk("R6 next to north", where(53), 0);
    chk("R6 next to south", where(52), 2);
    chk("R6 last to west", where(51), 3);
    chk("R1 four outputs", nout(), 4);
  endtask

  task automatic t_inject();
    step(4'b0111, mk(10, 0, 1, 61), mk(10, 0, 1, 62), mk(10, 0, 1, 63), 0,
         1, mk(0, 1, 3, 64));
    chk("R2 ready high with a free slot", int'(rdy_seen), 1);
    chk("R5 tie north-in wins west", where(61), 3);
    chk("R6 east-in deflected north", where(62), 0);
    chk("R6 south-in deflected east", where(63), 1);
    chk("R6 injected flit deflected south", where(64), 2);
    chk("R1 four outputs with injection", nout(), 4);
  endtask

  task automatic t_corner_low();
    my_x = 0; my_y = 0;
    step(4'b0111, mk(2, 3, 0, 71), mk(6, 3, 0, 72), mk(9, 3, 0, 73), 0, 1, mk(1, 2, 2, 74));
    chk("R2 corner ready low with both links busy", int'(rdy_seen), 0);
    chk("R9 missing south input ignored", where(73), NONE);
    chk("R5 older gets east at corner", where(72), 1);
    chk("R6 deflection to existing link only", where(71), 0);
    chk("R1 corner count", nout(), 2);
  endtask

  task automatic t_corner_high();
    my_x = 3; my_y = 3;
    step(4'b1100, 0, 0, mk(1, 3, 3, 81), mk(5, 0, 3, 82), 0, 0);
    chk("R8 local flit ejects", where(81), 4);
    chk("R4 west productive", where(82), 3);
    chk("R9 no north or east at far corner", int'(out_valid[1:0]), 0);
    my_x = 1; my_y = 1;
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 outputs idle in reset", nout(), 0);
    rst_n = 1;
    t_reset();
    t_single();
    t_two_prod();
    t_contend();
    t_tie();
    t_eject();
    t_full();
    t_inject();
    t_corner_low();
    t_corner_high();
    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule